// File: doc/BRIEF.md
# Cascadable Serial LCD Segment Driver

This block drives a static liquid-crystal display of up to 38 segments from a serial data stream. Bits enter a shift register on the falling edge of a serial clock, but only while an active-low select is asserted. A load strobe makes a bank of segment latches transparent so they follow the register, and the latches hold their value once the strobe drops.

Each segment output is its latched bit XOR-ed with a backplane square wave. The backplane comes from dividing an oscillator clock by a power of two. A latched 1 therefore drives the segment in antiphase (visible), and a latched 0 drives it in phase (dark). Three tap outputs, taken from register stages 30, 32 and the last stage, are retimed on the rising serial clock edge. They feed the serial input of a following driver or let the loaded pattern be read back.

A two-bit test input can replace the latched pattern with all-off, all-on or alternating segments. A power-good input forces the whole display flat at 0.

Top module: `lcd_seg_drv`

## Requirements
- R1: On each falling edge of `sclk_i` with `cs_ni` low, `din_i` enters stage 1 and every stage k takes the old value of stage k-1. Stage k is bit k-1 of the register, and segment k shows latch bit k-1.
- R2: A falling edge of `sclk_i` while `cs_ni` is high leaves the register unchanged.
- R3: `tap_a_o`, `tap_b_o` and `tap_c_o` show stages 30, 32 and NUM_SEG. They take those values only on the rising edge of `sclk_i`.
- R4: While `load_i` is high and `cs_ni` is low, the latches follow the register. When `load_i` returns low, they keep their value through later shifting.
- R5: A `load_i` pulse while `cs_ni` is high does not change the latches.
- R6: With `test_i` = 2'b00, a segment whose latch bit is 1 equals the inverse of `bp_o`, and a segment whose latch bit is 0 equals `bp_o`.
- R7: `bp_o` is a 50% duty square wave at the `osc_i` frequency divided by 2^DIV_LOG2. Each level lasts 2^(DIV_LOG2-1) oscillator cycles, and the wave starts low after reset.
- R8: With `test_i` = 2'b01, every segment equals `bp_o` (all off), whatever the latch holds.
- R9: With `test_i` = 2'b10, every segment equals the inverse of `bp_o` (all on).
- R10: With `test_i` = 2'b11, odd-numbered segments (1, 3, … = even bit indices) are on and even-numbered segments are off.
- R11: While `pwr_ok_i` is low, `bp_o` and every bit of `seg_o` are 0, whatever the mode or latch contents.
- R12: `rst_ni` low asynchronously clears the register, the latches, the taps and the divider, which leaves the display blank with `bp_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_i | input | 1 | Oscillator clock for the backplane divider |
| sclk_i | input | 1 | Serial clock: shifts on fall, taps update on rise |
| cs_ni | input | 1 | Chip select, active low |
| din_i | input | 1 | Serial data in |
| load_i | input | 1 | Latch strobe, transparent while high |
| test_i | input | 2 | Display mode: 00 normal, 01 all off, 10 all on, 11 alternating |
| pwr_ok_i | input | 1 | Supply good, active high; low blanks the display |
| seg_o | output | NUM_SEG | Segment drives, bit k-1 is segment k |
| bp_o | output | 1 | Backplane square wave |
| tap_a_o | output | 1 | Retimed stage TAP_A (30) |
| tap_b_o | output | 1 | Retimed stage TAP_B (32) |
| tap_c_o | output | 1 | Retimed last stage |

## Verification
The bench keeps the full 38-stage register with taps at 30 and 32, so the tap readback covers the real cascade positions. It lowers DIV_LOG2 to 3, which makes the backplane toggle every 4 oscillator cycles. A short sampling window then sees both backplane phases in every display mode, and the level width can be measured directly. The same shift sequence is used to check that the taps do not move before the rising edge and that select-high clocks and loads are ignored.

// File: rtl/lcd_drv_pkg.sv
`timescale 1ns/1ps
package lcd_drv_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_ALL_OFF = 2'b01,
    MODE_ALL_ON  = 2'b10,
    MODE_ALT     = 2'b11
  } disp_mode_e;
endpackage

// File: rtl/lcd_shift_reg.sv
`timescale 1ns/1ps
module lcd_shift_reg #(
  parameter int NUM_SEG = 38,
  parameter int TAP_A   = 30,
  parameter int TAP_B   = 32
) (
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               cs_ni,
  input  logic               din_i,
  output logic [NUM_SEG-1:0] sr_o,
  output logic               tap_a_o,
  output logic               tap_b_o,
  output logic               tap_c_o
);
  logic [NUM_SEG-1:0] sr_q;
  logic [2:0]         tap_q;

  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (!cs_ni) sr_q <= {sr_q[NUM_SEG-2:0], din_i};
  end

  // taps retimed on the opposite edge for the next device in the chain
  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) tap_q <= '0;
    else         tap_q <= {sr_q[NUM_SEG-1], sr_q[TAP_B-1], sr_q[TAP_A-1]};
  end

  assign sr_o    = sr_q;
  assign tap_a_o = tap_q[0];
  assign tap_b_o = tap_q[1];
  assign tap_c_o = tap_q[2];

  // R1
  shift_in_chk: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    !cs_ni |=> (sr_q[0] == $past(din_i)));
  // R2
  hold_desel_chk: assert property (@(negedge sclk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(sr_q));
  // R3
  tap_last_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
    1'b1 |=> (tap_c_o == $past(sr_q[NUM_SEG-1])));
endmodule

// File: rtl/lcd_seg_latch.sv
`timescale 1ns/1ps
module lcd_seg_latch #(
  parameter int NUM_SEG = 38
) (
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               cs_ni,
  input  logic [NUM_SEG-1:0] sr_i,
  output logic [NUM_SEG-1:0] lat_o
);
  logic ld_en;
  assign ld_en = load_i & ~cs_ni;

  // level-sensitive by intent: transparent while strobe is high
  always_latch begin
    if (!rst_ni)    lat_o <= '0;
    else if (ld_en) lat_o <= sr_i;
  end
endmodule

// File: rtl/lcd_bp_div.sv
`timescale 1ns/1ps
module lcd_bp_div #(
  parameter int DIV_LOG2 = 8
) (
  input  logic rst_ni,
  input  logic osc_i,
  output logic bp_o
);
  logic [DIV_LOG2-1:0] cnt_q;

  always_ff @(posedge osc_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign bp_o = cnt_q[DIV_LOG2-1];

  generate
    if (DIV_LOG2 > 1) begin : g_width_chk
      // R7
      bp_min_width_chk: assert property (@(posedge osc_i) disable iff (!rst_ni)
        $changed(bp_o) |=> $stable(bp_o));
    end
  endgenerate
endmodule

// File: rtl/lcd_seg_mux.sv
`timescale 1ns/1ps
module lcd_seg_mux
  import lcd_drv_pkg::*;
#(
  parameter int NUM_SEG = 38
) (
  input  logic               rst_ni,
  input  logic               osc_i,
  input  logic [1:0]         test_i,
  input  logic               pwr_ok_i,
  input  logic [NUM_SEG-1:0] lat_i,
  input  logic               bp_i,
  output logic [NUM_SEG-1:0] seg_o,
  output logic               bp_o
);
  disp_mode_e         mode;
  logic [NUM_SEG-1:0] alt_pat;
  logic [NUM_SEG-1:0] pat;

  assign mode = disp_mode_e'(test_i);

  generate
    for (genvar j = 0; j < NUM_SEG; j++) begin : g_alt
      assign alt_pat[j] = ((j % 2) == 0);  // segment j+1 odd -> on
    end
  endgenerate

  always_comb begin
    unique case (mode)
      MODE_ALL_OFF: pat = '0;
      MODE_ALL_ON:  pat = '1;
      MODE_ALT:     pat = alt_pat;
      default:      pat = lat_i;
    endcase
  end

  assign bp_o  = pwr_ok_i & bp_i;
  assign seg_o = pwr_ok_i ? (pat ^ {NUM_SEG{bp_i}}) : '0;

  // R11
  blank_chk: assert property (@(posedge osc_i) disable iff (!rst_ni)
    !pwr_ok_i |-> (seg_o == '0 && bp_o == 1'b0));
  // R8
  all_off_chk: assert property (@(posedge osc_i) disable iff (!rst_ni)
    (pwr_ok_i && test_i == 2'b01) |-> (seg_o == {NUM_SEG{bp_o}}));
  // R9
  all_on_chk: assert property (@(posedge osc_i) disable iff (!rst_ni)
    (pwr_ok_i && test_i == 2'b10) |-> (seg_o == ~{NUM_SEG{bp_o}}));
endmodule

// File: rtl/lcd_seg_drv.sv
`timescale 1ns/1ps
module lcd_seg_drv #(
  parameter int NUM_SEG  = 38,
  parameter int TAP_A    = 30,
  parameter int TAP_B    = 32,
  parameter int DIV_LOG2 = 8
) (
  input  logic               rst_ni,
  input  logic               osc_i,
  input  logic               sclk_i,
  input  logic               cs_ni,
  input  logic               din_i,
  input  logic               load_i,
  input  logic [1:0]         test_i,
  input  logic               pwr_ok_i,
  output logic [NUM_SEG-1:0] seg_o,
  output logic               bp_o,
  output logic               tap_a_o,
  output logic               tap_b_o,
  output logic               tap_c_o
);
  logic [NUM_SEG-1:0] sr;
  logic [NUM_SEG-1:0] lat;
  logic               bp_raw;

  lcd_shift_reg #(.NUM_SEG(NUM_SEG), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_sr (
    .rst_ni, .sclk_i, .cs_ni, .din_i,
    .sr_o(sr), .tap_a_o, .tap_b_o, .tap_c_o
  );

  lcd_seg_latch #(.NUM_SEG(NUM_SEG)) u_lat (
    .rst_ni, .load_i, .cs_ni, .sr_i(sr), .lat_o(lat)
  );

  lcd_bp_div #(.DIV_LOG2(DIV_LOG2)) u_div (
    .rst_ni, .osc_i, .bp_o(bp_raw)
  );

  lcd_seg_mux #(.NUM_SEG(NUM_SEG)) u_mux (
    .rst_ni, .osc_i, .test_i, .pwr_ok_i,
    .lat_i(lat), .bp_i(bp_raw), .seg_o, .bp_o
  );
endmodule

// File: tb/lcd_seg_drv_tb_top.sv
`timescale 1ns/1ps
module lcd_seg_drv_tb_top;
  localparam int N  = 38;
  localparam int DL = 3;
  localparam int HALF_BP = 1 << (DL - 1);

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sclk = 1'b0;
  logic         cs_ni = 1'b1;
  logic         din = 1'b0;
  logic         load = 1'b0;
  logic [1:0]   test = 2'b00;
  logic         pwr_ok = 1'b1;
  logic [N-1:0] seg;
  logic         bp, tap_a, tap_b, tap_c;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [N-1:0] PAT_V = 38'h2A5C3E91B7;
  localparam logic [N-1:0] PAT_W = 38'h1D36A0C54E;

  always #4 clk = ~clk;  // 125 MHz oscillator

  lcd_seg_drv #(.NUM_SEG(N), .TAP_A(30), .TAP_B(32), .DIV_LOG2(DL)) dut_i (
    .rst_ni(rst_ni), .osc_i(clk), .sclk_i(sclk), .cs_ni(cs_ni), .din_i(din),
    .load_i(load), .test_i(test), .pwr_ok_i(pwr_ok), .seg_o(seg), .bp_o(bp),
    .tap_a_o(tap_a), .tap_b_o(tap_b), .tap_c_o(tap_c)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // shift a pattern so that bit j ends in stage j+1
  task automatic shift_pat(input logic [N-1:0] v, input bit sel);
    cs_ni = ~sel;
    for (int k = N - 1; k >= 0; k--) begin
      din = v[k];
      #10 sclk = 1'b1;
      #20 sclk = 1'b0;
      #10;
    end
    cs_ni = 1'b1;
  endtask

  task automatic rise_only();
    cs_ni = 1'b1;
    #10 sclk = 1'b1;
    #20 sclk = 1'b0;
    #10;
  endtask

  task automatic pulse_load(input bit sel);
    cs_ni = ~sel;
    #10 load = 1'b1;
    #20 load = 1'b0;
    #10 cs_ni = 1'b1;
  endtask

  // compare segments against pattern XOR backplane over both phases
  task automatic check_segs(input string req, input logic [N-1:0] pat);
    int bad = 0;
    bit seen_hi = 0, seen_lo = 0;
    logic [N-1:0] last_act = '0, last_exp = '0;
    for (int c = 0; c < 4 * HALF_BP; c++) begin
      @(negedge clk);
      last_exp = pat ^ {N{bp}};
      last_act = seg;
      if (bp) seen_hi = 1; else seen_lo = 1;
      if (seg !== last_exp) bad++;
    end
    chk(bad == 0 && seen_hi && seen_lo, req, 64'(last_act), 64'(last_exp));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(bp == 1'b0 && seg == '0, "R12 display blank in reset", 64'({bp, seg}), 64'd0);
    chk({tap_c, tap_b, tap_a} == 3'b000, "R12 taps cleared", 64'({tap_c, tap_b, tap_a}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(bp == 1'b0, "R7 backplane starts low", 64'(bp), 64'd0);
    rise_only();
    chk({tap_c, tap_b, tap_a} == 3'b000, "R12 register cleared", 64'({tap_c, tap_b, tap_a}), 64'd0);
  endtask

  task automatic t_backplane();
    int hi_len = 0, lo_len = 0;
    @(posedge bp);
    @(negedge clk);
    while (bp) begin hi_len++; @(negedge clk); end
    while (!bp) begin lo_len++; @(negedge clk); end
    chk(hi_len == HALF_BP, "R7 high level width", 64'(hi_len), 64'(HALF_BP));
    chk(lo_len == HALF_BP, "R7 low level width", 64'(lo_len), 64'(HALF_BP));
  endtask

  task automatic t_shift_taps();
    shift_pat(PAT_V, 1'b1);
    chk(tap_a == PAT_V[30] && tap_b == PAT_V[32], "R3 taps wait for rising edge",
        64'({tap_b, tap_a}), 64'({PAT_V[32], PAT_V[30]}));
    rise_only();
    chk({tap_c, tap_b, tap_a} == {PAT_V[37], PAT_V[31], PAT_V[29]}, "R1 R3 taps after full shift",
        64'({tap_c, tap_b, tap_a}), 64'({PAT_V[37], PAT_V[31], PAT_V[29]}));
  endtask

  task automatic t_deselect_shift();
    shift_pat(~PAT_V, 1'b0);
    rise_only();
    chk({tap_c, tap_b, tap_a} == {PAT_V[37], PAT_V[31], PAT_V[29]}, "R2 no shift while deselected",
        64'({tap_c, tap_b, tap_a}), 64'({PAT_V[37], PAT_V[31], PAT_V[29]}));
  endtask

  task automatic t_load_normal();
    test = 2'b00;
    pulse_load(1'b1);
    check_segs("R6 normal mode shows latch V", PAT_V);
    shift_pat(PAT_W, 1'b1);
    check_segs("R4 latch holds V while shifting W", PAT_V);
    pulse_load(1'b0);
    check_segs("R5 deselected load ignored", PAT_V);
    pulse_load(1'b1);
    check_segs("R4 load copies W", PAT_W);
  endtask

  task automatic t_modes();
    logic [N-1:0] alt;
    for (int j = 0; j < N; j++) alt[j] = (j % 2 == 0);
    test = 2'b01; check_segs("R8 all off", '0);
    test = 2'b10; check_segs("R9 all on", '1);
    test = 2'b11; check_segs("R10 alternating", alt);
    test = 2'b00; check_segs("R6 normal restored", PAT_W);
  endtask

  task automatic t_power();
    int bad = 0;
    pwr_ok = 1'b0;
    for (int m = 0; m < 4; m++) begin
      test = 2'(m);
      for (int c = 0; c < 2 * HALF_BP; c++) begin
        @(negedge clk);
        if (bp !== 1'b0 || seg !== '0) bad++;
      end
    end
    chk(bad == 0, "R11 power loss blanks in all modes", 64'(bad), 64'd0);
    pwr_ok = 1'b1;
    test = 2'b00;
    check_segs("R11 display returns after power good", PAT_W);
  endtask

  initial begin
    t_reset();
    t_backplane();
    t_shift_taps();
    t_deselect_shift();
    t_load_normal();
    t_modes();
    t_power();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule